// File: doc/BRIEF.md
# Rational-Ratio Clock Enable Generator

This block models a configurable clock-rate converter in a purely synchronous way. Everything runs on one fast system clock. A one-cycle input strobe stands for each rising edge of a slower input clock. The block produces an output strobe whose long-run rate is the input rate times (FB+2)/(REF+2), where REF and FB are two 7-bit divider words. It also flags the output strobes that line up with an input edge, produces a strobe at half the output rate, and drives a second output that can be switched between those two or turned off.

A signed credit accumulator does the rate conversion. Each input strobe adds FB+2 units of credit. Each output event, issued at most one per system clock, spends REF+2 units. A power-down input, and any change to either divider word, clear all internal state. The first input strobe after that is therefore an aligned edge.

Input strobes must be spaced at least ceil((FB+2)/(REF+2))+1 system cycles apart, so that the events owed for one strobe are all issued before the next strobe arrives.

Top module: `rate_tick_gen`

## Requirements
- R1: Let R = ref_word_i+2 and F = fb_word_i+2, where each word is an unsigned 7-bit value. Over any run of R input strobes that starts at a cleared state, exactly F output strobes are produced.
- R2: Number the input strobes n = 0, 1, 2, ... from the last clear. After strobe n, the running total of output strobes owed is ceil((n+1)·F/R). Owed strobes appear one per system cycle on out_tick_o, and the first one appears in the cycle after the input strobe.
- R3: sync_o pulses together with the first output strobe caused by input strobe n exactly when n·F is a multiple of R. Over R strobes this is gcd(R,F) times.
- R4: half_o pulses together with the 1st, 3rd, 5th, ... output strobe after a clear, and with no others.
- R5: When aux_en_i=0, aux_o=0 and aux_valid_o=0. When aux_en_i=1 and aux_half_sel_i=0, aux_o follows sync_o. When aux_en_i=1 and aux_half_sel_i=1, aux_o follows half_o. In both enabled cases aux_valid_o=1.
- R6: While pd_ni=0, out_tick_o, sync_o, half_o, aux_o, out_valid_o and aux_valid_o are all 0 in the same cycle. All state is cleared and input strobes are ignored. The first strobe after release is aligned (R3 with n=0).
- R7: In a cycle where ref_word_i or fb_word_i differs from its value in the previous cycle, state is cleared and an input strobe is ignored. The stored words read as zero after reset. The next strobe is aligned and raises sync_o.
- R8: During and after reset every output strobe is 0 and no strobe is owed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pd_ni | input | 1 | Power-down, active low |
| in_tick_i | input | 1 | One-cycle strobe marking an input clock edge |
| ref_word_i | input | 7 | Reference word; divisor is word+2 |
| fb_word_i | input | 7 | Feedback word; multiplier is word+2 |
| aux_en_i | input | 1 | Enable for the second output |
| aux_half_sel_i | input | 1 | Second output source: 0 coincidence, 1 half rate |
| out_tick_o | output | 1 | Primary output strobe |
| out_valid_o | output | 1 | Primary output enabled |
| sync_o | output | 1 | Coincidence marker on aligned output strobes |
| half_o | output | 1 | Output strobe divided by two |
| aux_o | output | 1 | Second output strobe |
| aux_valid_o | output | 1 | Second output enabled |

## Verification
The bench drives five settings. The 5/4 setting tests fractional multiplication with coprime terms. The divide-by-5 setting (10/2) has a common factor, so it tells a correct coincidence rate (once every R/gcd strobes) apart from a naive once-per-R rate. The extreme 129/2 setting owes 65 back-to-back events per strobe and exercises the one-per-cycle drain. The 129/129 setting checks the unity ratio at the widest divisor, and 6/8 checks a ratio below one with a shared factor. A behavioural model built on ceiling arithmetic is compared with every output on every cycle. The bench also inserts a power-down and a word change, each coinciding with a strobe, to confirm that the strobe is ignored and that realignment follows.

// File: rtl/rtg_pkg.sv
`timescale 1ns/1ps
package rtg_pkg;
  localparam int WORD_W   = 7;
  localparam int CREDIT_W = 10;

  typedef enum logic [1:0] {
    AUX_OFF  = 2'd0,
    AUX_SYNC = 2'd1,
    AUX_HALF = 2'd2
  } aux_mode_e;
endpackage

// File: rtl/rtg_cfg_watch.sv
`timescale 1ns/1ps
module rtg_cfg_watch #(
  parameter int WORD_W = rtg_pkg::WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pd_ni,
  input  logic [WORD_W-1:0] ref_i,
  input  logic [WORD_W-1:0] fb_i,
  output logic              clear_o
);
  logic [WORD_W-1:0] ref_q, fb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q <= '0;
      fb_q  <= '0;
    end else begin
      ref_q <= ref_i;
      fb_q  <= fb_i;
    end
  end

  assign clear_o = !pd_ni || (ref_i != ref_q) || (fb_i != fb_q);
endmodule

// File: rtl/rtg_credit_acc.sv
`timescale 1ns/1ps
module rtg_credit_acc #(
  parameter int WORD_W   = rtg_pkg::WORD_W,
  parameter int CREDIT_W = rtg_pkg::CREDIT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              tick_i,
  input  logic [WORD_W-1:0] ref_i,
  input  logic [WORD_W-1:0] fb_i,
  output logic              emit_o,
  output logic              out_o,
  output logic              sync_o
);
  localparam int PAD = CREDIT_W - WORD_W;
  localparam logic signed [CREDIT_W-1:0] OFFSET = CREDIT_W'(2);

  logic signed [CREDIT_W-1:0] span_r, span_f, avail, credit_q;
  logic emit, out_q, sync_q;

  assign span_r = $signed({{PAD{1'b0}}, ref_i}) + OFFSET;
  assign span_f = $signed({{PAD{1'b0}}, fb_i}) + OFFSET;
  assign avail  = credit_q + (tick_i ? span_f : '0);
  // positive credit means an output edge is owed
  assign emit   = !avail[CREDIT_W-1] && (avail != '0);
  assign emit_o = emit && !clear_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      credit_q <= '0;
      out_q    <= 1'b0;
      sync_q   <= 1'b0;
    end else if (clear_i) begin
      credit_q <= '0;
      out_q    <= 1'b0;
      sync_q   <= 1'b0;
    end else begin
      credit_q <= avail - (emit ? span_r : '0);
      out_q    <= emit;
      // zero credit at an input edge: output edge lands exactly on it
      sync_q   <= tick_i && (credit_q == '0);
    end
  end

  assign out_o  = out_q;
  assign sync_o = sync_q;

  // R3
  sync_has_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_q |-> out_q);

  // R7
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (credit_q == '0) && !out_q && !sync_q);
endmodule

// File: rtl/rtg_half_div.sv
`timescale 1ns/1ps
module rtg_half_div (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic ev_i,
  output logic half_o
);
  logic odd_q, half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      odd_q  <= 1'b0;
      half_q <= 1'b0;
    end else if (clear_i) begin
      odd_q  <= 1'b0;
      half_q <= 1'b0;
    end else begin
      half_q <= ev_i && !odd_q;
      if (ev_i) odd_q <= !odd_q;
    end
  end

  assign half_o = half_q;

  // R4
  half_alt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_q |=> !half_q);
endmodule

// File: rtl/rtg_aux_sel.sv
`timescale 1ns/1ps
module rtg_aux_sel
  import rtg_pkg::*;
(
  input  logic pd_ni,
  input  logic en_i,
  input  logic half_sel_i,
  input  logic sync_i,
  input  logic half_i,
  output logic aux_o,
  output logic valid_o
);
  aux_mode_e mode;

  always_comb begin
    if (!en_i || !pd_ni) mode = AUX_OFF;
    else if (half_sel_i) mode = AUX_HALF;
    else                 mode = AUX_SYNC;
  end

  always_comb begin
    unique case (mode)
      AUX_SYNC: aux_o = sync_i;
      AUX_HALF: aux_o = half_i;
      default:  aux_o = 1'b0;
    endcase
  end

  assign valid_o = (mode != AUX_OFF);
endmodule

// File: rtl/rate_tick_gen.sv
`timescale 1ns/1ps
module rate_tick_gen #(
  parameter int WORD_W   = rtg_pkg::WORD_W,
  parameter int CREDIT_W = rtg_pkg::CREDIT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pd_ni,
  input  logic              in_tick_i,
  input  logic [WORD_W-1:0] ref_word_i,
  input  logic [WORD_W-1:0] fb_word_i,
  input  logic              aux_en_i,
  input  logic              aux_half_sel_i,
  output logic              out_tick_o,
  output logic              out_valid_o,
  output logic              sync_o,
  output logic              half_o,
  output logic              aux_o,
  output logic              aux_valid_o
);
  logic clear, emit, out_q, sync_q, half_q;

  rtg_cfg_watch #(.WORD_W(WORD_W)) i_cfg (
    .clk_i, .rst_ni, .pd_ni,
    .ref_i   (ref_word_i),
    .fb_i    (fb_word_i),
    .clear_o (clear)
  );

  rtg_credit_acc #(.WORD_W(WORD_W), .CREDIT_W(CREDIT_W)) i_acc (
    .clk_i, .rst_ni,
    .clear_i (clear),
    .tick_i  (in_tick_i),
    .ref_i   (ref_word_i),
    .fb_i    (fb_word_i),
    .emit_o  (emit),
    .out_o   (out_q),
    .sync_o  (sync_q)
  );

  rtg_half_div i_half (
    .clk_i, .rst_ni,
    .clear_i (clear),
    .ev_i    (emit),
    .half_o  (half_q)
  );

  assign out_tick_o  = out_q  & pd_ni;
  assign sync_o      = sync_q & pd_ni;
  assign half_o      = half_q & pd_ni;
  assign out_valid_o = pd_ni;

  rtg_aux_sel i_aux (
    .pd_ni,
    .en_i       (aux_en_i),
    .half_sel_i (aux_half_sel_i),
    .sync_i     (sync_q),
    .half_i     (half_q),
    .aux_o,
    .valid_o    (aux_valid_o)
  );

  // R4
  half_with_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_q |-> out_q);

  // R6
  pd_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_ni |=> !out_q && !half_q && !sync_q);
endmodule

// File: tb/test_rate_tick_gen.sv
`timescale 1ns/1ps
module test_rate_tick_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd_n = 1'b1, in_tick = 1'b0, aux_en = 1'b0, aux_sel = 1'b0;
  logic [6:0] ref_w = '0, fb_w = '0;
  logic out_tick, out_valid, sync_o, half_o, aux_o, aux_valid;

  int n_chk = 0, n_fail = 0;
  int out_cnt = 0, sync_cnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rate_tick_gen i_rate_tick_gen (
    .clk_i(clk), .rst_ni(rst_n), .pd_ni(pd_n), .in_tick_i(in_tick),
    .ref_word_i(ref_w), .fb_word_i(fb_w),
    .aux_en_i(aux_en), .aux_half_sel_i(aux_sel),
    .out_tick_o(out_tick), .out_valid_o(out_valid), .sync_o(sync_o),
    .half_o(half_o), .aux_o(aux_o), .aux_valid_o(aux_valid)
  );

  function automatic int cdiv(int a, int b);
    return (a + b - 1) / b;
  endfunction

  function automatic int gcd(int a, int b);
    int x = a, y = b;
    while (y != 0) begin
      int t = x % y;
      x = y;
      y = t;
    end
    return x;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: ceiling arithmetic on the strobe index
  int m_n = 0, m_pend = 0, m_prev_ref = 0, m_prev_fb = 0;
  bit m_odd = 0, e_out = 0, e_sync = 0, e_half = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_n = 0; m_pend = 0; m_odd = 0; m_prev_ref = 0; m_prev_fb = 0;
      e_out = 0; e_sync = 0; e_half = 0;
    end else begin
      bit restart;
      restart = !pd_n || (int'(ref_w) != m_prev_ref) || (int'(fb_w) != m_prev_fb);
      m_prev_ref = ref_w;
      m_prev_fb  = fb_w;
      if (restart) begin
        m_n = 0; m_pend = 0; m_odd = 0; e_out = 0; e_sync = 0; e_half = 0;
      end else begin
        int r, f;
        r = int'(ref_w) + 2;
        f = int'(fb_w) + 2;
        e_sync = 0;
        if (in_tick) begin
          m_pend += cdiv((m_n + 1) * f, r) - cdiv(m_n * f, r);
          e_sync = ((m_n * f) % r) == 0;
          m_n++;
        end
        e_out = m_pend > 0;
        if (e_out) m_pend--;
        e_half = e_out && !m_odd;
        if (e_out) m_odd = !m_odd;
      end
    end
  end

  // per-cycle compare, away from the edges
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      bit x_out, x_sync, x_half, x_aux;
      x_out  = e_out  && pd_n;
      x_sync = e_sync && pd_n;
      x_half = e_half && pd_n;
      x_aux  = (aux_en && pd_n) ? (aux_sel ? x_half : x_sync) : 1'b0;
      chk(out_tick == x_out,  "R2 out_tick", out_tick, x_out);
      chk(sync_o == x_sync,   "R3 sync", sync_o, x_sync);
      chk(half_o == x_half,   "R4 half", half_o, x_half);
      chk(aux_o == x_aux,     "R5 aux", aux_o, x_aux);
      chk(aux_valid == (aux_en && pd_n), "R5 aux_valid", aux_valid, aux_en && pd_n);
      chk(out_valid == pd_n,  "R6 out_valid", out_valid, pd_n);
      if (out_tick) out_cnt++;
      if (sync_o) sync_cnt++;
    end
  end

  task automatic tick();
    @(negedge clk) in_tick = 1'b1;
    @(negedge clk) in_tick = 1'b0;
  endtask

  task automatic run_ratio(int rw, int fw, int periods, bit en, bit sel);
    int r, f, gap;
    r = rw + 2;
    f = fw + 2;
    gap = cdiv(f, r) + 2;
    @(negedge clk);
    ref_w = 7'(rw); fb_w = 7'(fw); aux_en = en; aux_sel = sel;
    repeat (2) @(negedge clk);
    out_cnt = 0; sync_cnt = 0;
    for (int k = 0; k < r * periods; k++) begin
      tick();
      repeat (gap - 1) @(negedge clk);
    end
    repeat (gap) @(negedge clk);
    #2;
    // R1
    chk(out_cnt == f * periods, "R1 out count", out_cnt, f * periods);
    // R3
    chk(sync_cnt == periods * gcd(r, f), "R3 sync count", sync_cnt, periods * gcd(r, f));
  endtask

  task automatic finish_run();
    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R8
    chk(out_tick == 0 && sync_o == 0 && half_o == 0 && aux_o == 0,
        "R8 outputs in reset", {out_tick, sync_o, half_o, aux_o}, 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    // R8
    chk(out_tick == 0, "R8 idle after reset", out_tick, 0);

    run_ratio(2, 3, 3, 1'b1, 1'b0);     // 5/4
    run_ratio(8, 0, 2, 1'b1, 1'b1);     // divide by 5
    run_ratio(0, 127, 2, 1'b0, 1'b0);   // 129/2
    run_ratio(127, 127, 1, 1'b1, 1'b1); // unity at widest divisor
    run_ratio(6, 4, 3, 1'b1, 1'b0);     // 6/8

    // R6: drop power-down in the middle of a drain; outputs drop the same cycle
    @(negedge clk) ref_w = 7'd0; fb_w = 7'd127; aux_en = 1'b1; aux_sel = 1'b1;
    repeat (2) @(negedge clk);
    tick();
    repeat (3) @(negedge clk);
    pd_n = 1'b0;
    #1;
    chk(out_tick == 0 && out_valid == 0 && aux_valid == 0, "R6 gated at once",
        {out_tick, out_valid, aux_valid}, 0);
    tick();
    #1;
    chk(out_tick == 0, "R6 strobe ignored", out_tick, 0);
    @(negedge clk) pd_n = 1'b1;
    @(negedge clk);
    tick();
    #1;
    chk(sync_o == 1 && out_tick == 1, "R6 aligned after release", {sync_o, out_tick}, 3);
    repeat (70) @(negedge clk);

    // R7: word change coinciding with a strobe
    @(negedge clk) ref_w = 7'd2; fb_w = 7'd3; in_tick = 1'b1;
    @(negedge clk) in_tick = 1'b0;
    #1;
    chk(out_tick == 0, "R7 strobe in change cycle ignored", out_tick, 0);
    tick();
    #1;
    chk(sync_o == 1, "R7 first strobe after change aligned", sync_o, 1);
    repeat (5) @(negedge clk);
    tick();
    #1;
    chk(sync_o == 0, "R7 second strobe not aligned", sync_o, 0);
    repeat (5) @(negedge clk);

    finish_run();
  end
endmodule